// File: doc/BRIEF.md
# SMBus Register Slave with Packet Error Code

This block is a serial management bus target that gives a host byte-wide access to a bank of internal registers. The bank lives outside the block and is reached through a small port: an address, write data, a one-cycle write strobe, and combinational read data. The bus pins are sampled on the system clock, and SDA is driven open-drain through an output enable. The block answers one fixed 7-bit address. The first data byte of every write loads an internal pointer. A second data byte is written to the register that the pointer selects. A read returns the pointed register without resending the pointer.

A CRC-8 packet error code (polynomial x^8+x^2+x+1, 0x07, initial value 0x00) runs over every byte of a transaction, address byte included. On a read it is sent only when the master acknowledges the data byte and clocks once more. On a write, a third data byte is compared with it, and a mismatch cancels the write. While the `alert_in` input is high, the block also answers a read at the alert response address with its own address, and it steps aside if it loses bit-wise arbitration. If SCL stays low too long while a transaction is open, the block frees SDA and goes idle. A configuration input turns this timeout off.

Top module: `smb_regslave`

## Requirements
- R1: After reset, SDA is released (`sda_oe`=0), `reg_we` is 0 and the pointer (`reg_addr`) is 0x00.
- R2: Only the address byte 0x98 (7-bit 0x4C with a write bit) or 0x99 (0x4C with a read bit) is acknowledged, by pulling SDA low in the ninth clock. Any other address byte gets no acknowledge, and the rest of that transaction is ignored: no pointer change and no register write.
- R3: A write with a single data byte loads that byte into the pointer and writes no register.
- R4: A write with two data bytes writes the second byte to the register selected by the first, with one `reg_we` pulse that follows the STOP.
- R5: A read (address byte 0x99) returns the register at the current pointer and leaves the pointer unchanged, so repeated reads return the same register.
- R6: If the master acknowledges a read data byte, the next byte sent is the CRC-8 (polynomial 0x07, initial 0x00, MSB first) over the address byte and the data byte. Any byte after that reads as 0xFF.
- R7: In a write with three data bytes, the third byte is checked against the CRC-8 over the address, pointer and data bytes. On a match the write is performed. On a mismatch no register is written. The third byte is acknowledged in both cases.
- R8: While `alert_in` is 1, a read at the alert response address (byte 0x19, that is 7-bit 0x0C with a read bit) is acknowledged and returns 0x98. While `alert_in` is 0, that byte is not acknowledged.
- R9: While sending, if the block leaves SDA high for a 1 and samples SDA low on the rising edge of SCL, it releases SDA for the rest of the transaction.
- R10: If SCL is held low for `TMO_CYC` system clocks while a transaction is open, the block releases SDA, goes idle and drops any pending write. When `tmo_off` is 1, this timeout never fires.
- R11: A START at any point aborts the transaction in progress, drops its pending write and begins a new address reception. This is how a pointer write followed by a repeated START and a read works.
- R12: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_o | output | 1 | Level driven onto SDA when enabled (always 0) |
| sda_oe | output | 1 | SDA output enable; 1 pulls the line low |
| alert_in | input | 1 | Alert pending; enables the alert response address |
| tmo_off | input | 1 | 1 disables the bus inactivity timeout |
| reg_addr | output | AW | Pointer: register selected for read and write |
| reg_wdata | output | 8 | Data for the register write |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Contents of the register at `reg_addr` |

## Verification
If the bit counter or the state machine slips by a single bit, the next acknowledge moves out of the ninth clock. The host sees that at once as a NACK or as a corrupted byte. A wrong pointer does not show up until the next read, which returns a different register, or until the next write, whose strobe lands at an address that the port exposes. A fault in the running CRC stays hidden in plain transfers. It appears only in the PEC byte of a read or as a wrongly accepted or rejected write, so the packet error code paths are exercised with both good and corrupted codes. A broken timeout shows as SDA still held low after SCL has been kept low for longer than the limit.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,   // no transaction open
    ST_ADDR,   // shifting in the address byte
    ST_AACK,   // driving acknowledge for the address
    ST_WBYTE,  // shifting in a write data byte
    ST_WACK,   // driving acknowledge for a data byte
    ST_RBYTE,  // shifting out a read byte
    ST_RACK,   // waiting for the master acknowledge
    ST_RNEXT,  // master acknowledged, load the following byte
    ST_PARK    // not addressed or finished: ignore until START/STOP
  } smb_state_t;

  typedef enum logic [1:0] {
    MD_NONE,
    MD_WRITE,
    MD_READ,
    MD_ALERT
  } smb_mode_t;

  // One byte through CRC-8, polynomial 0x07, MSB first.
  function automatic logic [7:0] crc8_step(input logic [7:0] crc,
                                           input logic [7:0] data);
    logic [7:0] c;
    logic       fb;
    c = crc;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ data[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rd);
    return {a, rd};
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_p    <= scl_pipe[STAGES-1];
      sda_p    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_q     = scl_pipe[STAGES-1];
  assign sda_q     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  // SDA may move under a high SCL only for START or STOP
  assign start_evt = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_evt  = scl_q & scl_p & ~sda_p & sda_q;

endmodule

// File: rtl/smb_bus_timer.sv
module smb_bus_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic scl_low,
  input  logic off,
  output logic expire
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;
  logic          run;

  assign run    = armed & scl_low & ~off;
  assign expire = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || expire) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LIMIT));

  p_off_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    off |-> !expire);

endmodule

// File: rtl/smb_regslave.sv
module smb_regslave
  import smb_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h4C,
  parameter logic [6:0]  ARA_ADDR = 7'h0C,
  parameter int unsigned TMO_CYC  = 1000000,
  parameter int          AW       = 8,
  parameter int          SYNC     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_o,
  output logic          sda_oe,
  input  logic          alert_in,
  input  logic          tmo_off,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  output logic          reg_we,
  input  logic [7:0]    reg_rdata
);

  localparam logic [7:0] WR_BYTE  = addr_byte(DEV_ADDR, 1'b0);
  localparam logic [7:0] RD_BYTE  = addr_byte(DEV_ADDR, 1'b1);
  localparam logic [7:0] ARA_BYTE = addr_byte(ARA_ADDR, 1'b1);

  // named bus events
  logic scl_q, sda_q, scl_rise, scl_fall, start_evt, stop_evt, tmo_hit;

  smb_line_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  smb_state_t    state;
  smb_mode_t     mode, hit_mode;
  logic [3:0]    bitcnt;
  logic [7:0]    sh, tx, tx_hold, crc, wdata;
  logic [AW-1:0] ptr;
  logic [2:0]    wcnt;
  logic          rcnt, pec_ok, addr_hit;

  smb_bus_timer #(.LIMIT(TMO_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n), .armed(state != ST_IDLE), .scl_low(~scl_q),
    .off(tmo_off), .expire(tmo_hit)
  );

  // events brought out for the assertions
  logic byte_in_done, commit_ok, arb_lost;
  assign byte_in_done = scl_fall && (bitcnt == 4'd8) &&
                        (state == ST_ADDR || state == ST_WBYTE);
  assign commit_ok    = (mode == MD_WRITE) &&
                        ((wcnt == 3'd2) || (wcnt == 3'd3 && pec_ok));
  assign arb_lost     = scl_rise && (state == ST_RBYTE) && tx[7] && !sda_q;

  always_comb begin
    addr_hit = 1'b1;
    hit_mode = MD_NONE;
    if (sh == WR_BYTE)                     hit_mode = MD_WRITE;
    else if (sh == RD_BYTE)                hit_mode = MD_READ;
    else if (alert_in && sh == ARA_BYTE)   hit_mode = MD_ALERT;
    else                                   addr_hit = 1'b0;
  end

  logic [7:0] first_tx, next_tx;
  assign first_tx = (mode == MD_ALERT) ? WR_BYTE : reg_rdata;
  assign next_tx  = rcnt ? 8'hFF : crc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      mode    <= MD_NONE;
      bitcnt  <= '0;
      sh      <= '0;
      tx      <= '1;
      tx_hold <= '0;
      crc     <= '0;
      wdata   <= '0;
      ptr     <= '0;
      wcnt    <= '0;
      rcnt    <= 1'b0;
      pec_ok  <= 1'b0;
      sda_oe  <= 1'b0;
      reg_we  <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (tmo_hit) begin
        state  <= ST_IDLE;
        mode   <= MD_NONE;
        wcnt   <= '0;
        sda_oe <= 1'b0;
      end else if (start_evt) begin
        state  <= ST_ADDR;
        mode   <= MD_NONE;
        bitcnt <= '0;
        sh     <= '0;
        crc    <= '0;
        wcnt   <= '0;
        rcnt   <= 1'b0;
        pec_ok <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        reg_we <= commit_ok;
        state  <= ST_IDLE;
        mode   <= MD_NONE;
        wcnt   <= '0;
        sda_oe <= 1'b0;
      end else if (scl_rise) begin
        case (state)
          ST_ADDR, ST_WBYTE: begin
            sh     <= {sh[6:0], sda_q};
            bitcnt <= bitcnt + 4'd1;
          end
          ST_RBYTE: begin
            if (arb_lost) state <= ST_PARK;
            bitcnt <= bitcnt + 4'd1;
          end
          ST_RACK: state <= sda_q ? ST_PARK : ST_RNEXT;
          default: ;
        endcase
      end else if (scl_fall) begin
        case (state)
          ST_ADDR: if (bitcnt == 4'd8) begin
            if (addr_hit) begin
              sda_oe <= 1'b1;
              mode   <= hit_mode;
              crc    <= crc8_step(crc, sh);
              state  <= ST_AACK;
            end else begin
              state  <= ST_PARK;
            end
          end
          ST_AACK: begin
            bitcnt <= '0;
            if (mode == MD_WRITE) begin
              sda_oe <= 1'b0;
              state  <= ST_WBYTE;
            end else begin
              tx      <= first_tx;
              tx_hold <= first_tx;
              sda_oe  <= ~first_tx[7];
              state   <= ST_RBYTE;
            end
          end
          ST_WBYTE: if (bitcnt == 4'd8) begin
            case (wcnt)
              3'd0:    ptr    <= sh[AW-1:0];
              3'd1:    wdata  <= sh;
              3'd2:    pec_ok <= (sh == crc);
              default: ;
            endcase
            crc    <= crc8_step(crc, sh);
            if (wcnt != 3'd7) wcnt <= wcnt + 3'd1;
            sda_oe <= 1'b1;
            state  <= ST_WACK;
          end
          ST_WACK: begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            state  <= ST_WBYTE;
          end
          ST_RBYTE: begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              crc    <= crc8_step(crc, tx_hold);
              state  <= ST_RACK;
            end else begin
              tx     <= {tx[6:0], 1'b1};
              sda_oe <= ~tx[6];
            end
          end
          ST_RNEXT: begin
            tx      <= next_tx;
            tx_hold <= next_tx;
            rcnt    <= 1'b1;
            sda_oe  <= ~next_tx[7];
            bitcnt  <= '0;
            state   <= ST_RBYTE;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_o     = 1'b0;
  assign reg_addr  = ptr;
  assign reg_wdata = wdata;

  // assertions next to the logic they guard
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  p_ack_driven_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AACK || state == ST_WACK) |-> sda_oe);

  p_we_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(stop_evt));

  p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  p_ptr_hold_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_READ) |=> $stable(ptr));

  p_lost_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> (!sda_oe && state == ST_PARK));

  p_tmo_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (!sda_oe && state == ST_IDLE));

  p_start_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !tmo_hit) |=> (state == ST_ADDR && bitcnt == 4'd0));

  p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_q);

endmodule

// File: tb/smb_regslave_tb.sv
module smb_regslave_tb;

  localparam int TMO = 200;
  localparam int Q   = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic alert = 1'b0, tmo_off = 1'b0;
  wire  sda_oe, sda_o, reg_we;
  wire  [7:0] reg_addr, reg_wdata;
  wire  sda_line = sda_oe ? (sda_o & m_sda) : m_sda;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  wire  [7:0] reg_rdata = mem[reg_addr];

  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  smb_regslave #(.TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe(sda_oe), .alert_in(alert), .tmo_off(tmo_off),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata)
  );

  int n_chk = 0, n_fail = 0, oe_viol = 0;
  logic last_oe;
  logic oe_prev = 1'b0;

  // R12 monitor: enable may only move while SCL is low
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && m_scl) oe_viol++;
    oe_prev = sda_oe;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bcrc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic wt(input int n); repeat (n) @(posedge clk); endtask

  task automatic bstart();
    m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b0; wt(Q); m_scl = 1'b0; wt(Q);
  endtask

  task automatic bstop();
    m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b1; wt(Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wt(Q); m_scl = 1'b1; wt(2 * Q); m_scl = 1'b0; wt(Q);
  endtask

  task automatic recv_bit(output logic v, input int hold);
    m_sda = 1'b1; wt(Q + hold);
    @(negedge clk) last_oe = sda_oe;
    m_scl = 1'b1; wt(Q);
    @(negedge clk) v = sda_line;
    wt(Q); m_scl = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int hold, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(v, hold);
    ack = ~v;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin recv_bit(v, 0); b[i] = v; end
    send_bit(~mack);
  endtask

  // pec_mode: 0 none, 1 correct code, 2 corrupted code
  task automatic do_write(input logic [7:0] p, input logic [7:0] d,
                          input int pec_mode, output logic all_ack);
    logic a0, a1, a2, a3;
    logic [7:0] c;
    c = bcrc(bcrc(bcrc(8'h00, 8'h98), p), d);
    bstart();
    send_byte(8'h98, 0, a0);
    send_byte(p, 0, a1);
    send_byte(d, 0, a2);
    a3 = 1'b1;
    if (pec_mode != 0) send_byte((pec_mode == 1) ? c : (c ^ 8'h01), 0, a3);
    bstop();
    wt(4);
    all_ack = a0 & a1 & a2 & a3;
    if (pec_mode != 2) exp_mem[p] = d;
  endtask

  task automatic do_ptr(input logic [7:0] p, output logic all_ack);
    logic a0, a1;
    bstart(); send_byte(8'h98, 0, a0); send_byte(p, 0, a1); bstop(); wt(4);
    all_ack = a0 & a1;
  endtask

  task automatic do_read(output logic [7:0] d, output logic ack);
    bstart(); send_byte(8'h99, 0, ack); recv_byte(1'b0, d); bstop(); wt(4);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    wt(190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic ack, a2;
    logic [7:0] d, p2, pec;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      exp_mem[i] = 8'(i) ^ 8'h5A;
    end
    wt(5);
    @(negedge clk);
    check("R1 sda_oe", sda_oe, 0);
    check("R1 reg_we", reg_we, 0);
    check("R1 reg_addr", reg_addr, 0);
    rst_n = 1'b1;
    wt(5);

    // R2: sweep all 7-bit addresses with the write bit
    for (int a = 0; a < 128; a++) begin
      bstart(); send_byte({7'(a), 1'b0}, 0, ack); bstop();
      check($sformatf("R2 ack addr %0h", a), ack, (a == 'h4C));
    end
    // R2: foreign address followed by data is ignored
    bstart(); send_byte(8'h9A, 0, ack); send_byte(8'h10, 0, a2); send_byte(8'hEE, 0, a2);
    bstop(); wt(4);
    check("R2 foreign ack", ack, 0);
    check("R2 foreign no write", mem[8'h10], exp_mem[8'h10]);
    check("R2 foreign ptr", reg_addr, 0);

    // R3: send byte sets the pointer only
    foreach (p2_list[k]) begin
      do_ptr(p2_list[k], ack);
      check("R3 ack", ack, 1);
      check("R3 pointer", reg_addr, p2_list[k]);
      check("R3 no write", mem[p2_list[k]], exp_mem[p2_list[k]]);
    end

    // R4: write byte
    do_write(8'h10, 8'hC3, 0, ack); check("R4 ack", ack, 1); check("R4 data", mem[8'h10], 8'hC3);
    do_write(8'h7F, 8'h00, 0, ack); check("R4 data", mem[8'h7F], 8'h00);
    do_write(8'hFE, 8'h5A, 0, ack); check("R4 data", mem[8'hFE], 8'h5A);
    check("R4 pointer", reg_addr, 8'hFE);
    check("R4 neighbour", mem[8'hFD], exp_mem[8'hFD]);

    // R5: read from the pointer, repeatedly
    do_ptr(8'h22, ack);
    do_read(d, ack); check("R5 ack", ack, 1); check("R5 first read", d, exp_mem[8'h22]);
    do_read(d, ack); check("R5 second read", d, exp_mem[8'h22]);
    check("R5 pointer kept", reg_addr, 8'h22);
    do_ptr(8'h10, ack); do_read(d, ack); check("R5 read after write", d, 8'hC3);

    // R6: read with PEC and trailing filler
    do_ptr(8'h33, ack);
    bstart(); send_byte(8'h99, 0, ack);
    recv_byte(1'b1, d); recv_byte(1'b1, pec); recv_byte(1'b0, p2); bstop(); wt(4);
    check("R6 data", d, exp_mem[8'h33]);
    check("R6 pec", pec, bcrc(bcrc(8'h00, 8'h99), exp_mem[8'h33]));
    check("R6 filler", p2, 8'hFF);

    // R7: write with PEC, good and bad
    do_write(8'h40, 8'h9E, 1, ack); check("R7 good ack", ack, 1); check("R7 good write", mem[8'h40], 8'h9E);
    do_write(8'h41, 8'h11, 2, ack); check("R7 bad ack", ack, 1); check("R7 bad discarded", mem[8'h41], exp_mem[8'h41]);

    // R8: alert response address
    alert = 1'b1;
    bstart(); send_byte(8'h19, 0, ack); recv_byte(1'b0, d); bstop(); wt(4);
    check("R8 ara ack", ack, 1); check("R8 ara returns", d, 8'h98);
    alert = 1'b0;
    bstart(); send_byte(8'h19, 0, ack); bstop(); wt(4);
    check("R8 ara no alert", ack, 0);

    // R9: arbitration loss on a 1 bit
    do_write(8'h50, 8'h80, 0, ack);
    bstart(); send_byte(8'h99, 0, ack);
    send_bit(1'b0);
    for (int i = 6; i >= 0; i--) begin recv_bit(a2, 0); d[i] = a2; end
    send_bit(1'b1); bstop(); wt(4);
    check("R9 released after loss", d[6:0], 7'h7F);

    // R10: timeout during an acknowledge
    bstart(); send_byte(8'h98, 0, ack); send_byte(8'h60, 0, ack);
    send_byte(8'h3C, 300, ack); bstop(); wt(4);
    check("R10 oe released", last_oe, 0);
    check("R10 write dropped", mem[8'h60], exp_mem[8'h60]);
    tmo_off = 1'b1;
    bstart(); send_byte(8'h98, 0, ack); send_byte(8'h61, 0, ack);
    send_byte(8'hC7, 300, ack); bstop(); wt(4);
    check("R10 disabled oe held", last_oe, 1);
    check("R10 disabled ack", ack, 1);
    check("R10 disabled write", mem[8'h61], 8'hC7);
    exp_mem[8'h61] = 8'hC7;
    tmo_off = 1'b0;

    // R11: repeated START
    bstart(); send_byte(8'h98, 0, ack); send_byte(8'h70, 0, ack);
    bstart(); send_byte(8'h99, 0, ack); recv_byte(1'b0, d); bstop(); wt(4);
    check("R11 ptr then read", d, exp_mem[8'h70]);
    bstart(); send_byte(8'h98, 0, ack); send_byte(8'h71, 0, ack); send_byte(8'hAA, 0, ack);
    bstart(); send_byte(8'h98, 0, ack); send_byte(8'h72, 0, ack); bstop(); wt(4);
    check("R11 aborted write", mem[8'h71], exp_mem[8'h71]);
    check("R11 new pointer", reg_addr, 8'h72);

    check("R12 sda_oe moves with SCL high", oe_viol, 0);
    finish_up();
  end

  logic [7:0] p2_list [4] = '{8'h00, 8'h37, 8'hA5, 8'hFF};

endmodule